// File: doc/BRIEF.md
# DDR3 Command and Address Decoder

This block sits on the controller side of a DDR3 memory channel and turns the raw command bus into decoded events. On every rising clock edge it samples chip select, the three row/column/write command lines, the bank address and the address bus. When the sampled command is accepted, it raises exactly one bit of a one-hot strobe vector for one cycle. It also latches the fields that belong to that command: bank, row, column, the auto-precharge flag, the resolved burst length, and the mode-register index and opcode.

Address line 10 has two meanings. On reads and writes it is the auto-precharge flag. On a precharge it chooses between one bank and all banks. The burst length of each access comes from a burst-mode register that a LOAD MODE to mode register 0 writes. That mode is either fixed length-8, fixed chop-4, or chosen per access from address line 12.

Clock enable is tracked by a two-state machine. `CK_HALT` is the reset state. It moves to `CK_RUN` when clock enable is sampled high and goes back to `CK_HALT` when clock enable is sampled low. A command is accepted only in `CK_RUN` with clock enable high at the same edge. The burst mode is kept as a four-state register: `BM_FIX8`, `BM_OTF`, `BM_FIX4` and `BM_RSV`. A LOAD MODE to mode register 0 moves it to the state named by opcode bits [1:0]. Every other event leaves it where it is.

Top module: `ddr_cmd_decode`

## Requirements
- R1: Inputs are sampled on the rising clock edge. The decoded result appears on `cmd_stb_o` after that edge and lasts one cycle. At most one strobe bit is high. Bit positions: 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE one bank, 4 PRECHARGE all, 5 REFRESH, 6 LOAD MODE, 7 NOP/DESELECT.
- R2: An accepted command with `cs_n_i` high raises only bit 7, whatever the other command lines carry.
- R3: With `cs_n_i` low, {ras_n, cas_n, we_n} decodes as follows: 011 ACTIVATE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 LOAD MODE, 111 NOP. The code 110 raises no strobe.
- R4: On PRECHARGE, address bit 10 low raises bit 3 and latches `bank_o` from the bank input. Address bit 10 high raises bit 4 and leaves `bank_o` unchanged.
- R5: On READ or WRITE, `bank_o` takes the bank input, `col_o` takes address bits [9:0], and `auto_pre_o` takes address bit 10.
- R6: On ACTIVATE, `bank_o` takes the bank input and `row_o` takes the full address.
- R7: On LOAD MODE, `mr_idx_o` takes bank bits [1:0] and `mr_op_o` takes the full address. When the index is 0, `burst_mode_o` becomes address bits [1:0] after the same edge (00 fixed length-8, 01 per-access, 10 fixed chop-4, 11 reserved).
- R8: On READ or WRITE, `burst8_o` is set as follows: 0 in fixed chop-4 mode; address bit 12 in per-access mode; 1 in fixed length-8 mode and in the reserved mode.
- R9: A command is accepted only when clock enable is sampled high at that edge and was also sampled high at the previous edge. `clk_run_o` shows the sampled clock enable. An ignored command raises no strobe and leaves every latched field and the burst mode unchanged.
- R10: The active-low reset acts asynchronously. It clears the strobes, every latched field and `clk_run_o`, and returns the burst mode to fixed length-8 (00).
- R11: A LOAD MODE with a bank index other than 0 leaves the burst mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge samples |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe command line, active low |
| cas_n_i | input | 1 | Column strobe command line, active low |
| we_n_i | input | 1 | Write enable command line, active low |
| ba_i | input | BANK_W | Bank address |
| addr_i | input | ADDR_W | Address / opcode |
| cmd_stb_o | output | 8 | One-hot command strobe |
| bank_o | output | BANK_W | Latched target bank |
| row_o | output | ADDR_W | Latched row address |
| col_o | output | COL_W | Latched column address |
| auto_pre_o | output | 1 | Latched auto-precharge flag |
| burst8_o | output | 1 | Latched burst length: 1 length-8, 0 chop-4 |
| mr_idx_o | output | 2 | Latched mode-register index |
| mr_op_o | output | ADDR_W | Latched mode-register opcode |
| clk_run_o | output | 1 | Clock-enable state (1 = CK_RUN) |
| burst_mode_o | output | 2 | Current burst-mode encoding |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 3-bit bank and a 10-bit column. With that configuration it can sweep all sixteen chip-select and command-line combinations, against both values of address bit 10 and address bit 12, under each of the four burst-mode encodings. Separate sequences check the first-edge rule of clock enable, LOAD MODE to a non-zero index, and an asynchronous reset applied between clock edges.

// File: rtl/ddrcmd_pkg.sv
package ddrcmd_pkg;

    localparam int STB_W  = 8;
    localparam int S_ACT  = 0;
    localparam int S_RD   = 1;
    localparam int S_WR   = 2;
    localparam int S_PRE  = 3;
    localparam int S_PREA = 4;
    localparam int S_REF  = 5;
    localparam int S_MRS  = 6;
    localparam int S_NOP  = 7;

    typedef enum logic {
        CK_HALT = 1'b0,
        CK_RUN  = 1'b1
    } cke_state_e;

    typedef enum logic [1:0] {
        BM_FIX8 = 2'b00,
        BM_OTF  = 2'b01,
        BM_FIX4 = 2'b10,
        BM_RSV  = 2'b11
    } burst_mode_e;

endpackage

// File: rtl/cke_fsm.sv
module cke_fsm
    import ddrcmd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic cke_i,
    output logic accept_o,
    output logic run_o
);

    cke_state_e state_q;
    cke_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= CK_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        unique case (state_q)
            CK_HALT: begin
                if (cke_i) state_d = CK_RUN;
            end
            CK_RUN: begin
                accept_o = cke_i;
                if (!cke_i) state_d = CK_HALT;
            end
            default: state_d = CK_HALT;
        endcase
    end

    assign run_o = (state_q == CK_RUN);

    // R9: a rising clock enable is only a wake-up, never an accepted edge
    p_wake_not_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!run_o && cke_i) |-> !accept_o);

endmodule

// File: rtl/cmd_classify.sv
module cmd_classify
    import ddrcmd_pkg::*;
(
    input  logic             cs_n_i,
    input  logic             ras_n_i,
    input  logic             cas_n_i,
    input  logic             we_n_i,
    input  logic             all_bank_i,
    output logic [STB_W-1:0] kind_o
);

    always_comb begin
        kind_o = '0;
        if (cs_n_i) begin
            kind_o[S_NOP] = 1'b1;
        end else begin
            unique case ({ras_n_i, cas_n_i, we_n_i})
                3'b011:  kind_o[S_ACT] = 1'b1;
                3'b101:  kind_o[S_RD]  = 1'b1;
                3'b100:  kind_o[S_WR]  = 1'b1;
                3'b010: begin
                    if (all_bank_i) kind_o[S_PREA] = 1'b1;
                    else            kind_o[S_PRE]  = 1'b1;
                end
                3'b001:  kind_o[S_REF] = 1'b1;
                3'b000:  kind_o[S_MRS] = 1'b1;
                3'b111:  kind_o[S_NOP] = 1'b1;
                default: kind_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/burst_ctl.sv
module burst_ctl
    import ddrcmd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       load_i,
    input  logic [1:0] mr_idx_i,
    input  logic [1:0] op_i,
    input  logic       otf_sel_i,
    output logic [1:0] mode_o,
    output logic       bl8_o
);

    burst_mode_e mode_q;
    burst_mode_e mode_d;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            mode_q <= BM_FIX8;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        if (load_i && (mr_idx_i == 2'd0)) begin
            mode_d = burst_mode_e'(op_i);
        end
    end

    always_comb begin
        unique case (mode_q)
            BM_FIX8: bl8_o = 1'b1;
            BM_OTF:  bl8_o = otf_sel_i;
            BM_FIX4: bl8_o = 1'b0;
            BM_RSV:  bl8_o = 1'b1;
            default: bl8_o = 1'b1;
        endcase
    end

    assign mode_o = mode_q;

    // R11: loading any register other than index 0 keeps the burst mode
    p_other_mr_keeps_mode_r11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_i && (mr_idx_i != 2'd0)) |=> $stable(mode_q));

endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddrcmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        cmd_stb_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              auto_pre_o,
    output logic              burst8_o,
    output logic [1:0]        mr_idx_o,
    output logic [ADDR_W-1:0] mr_op_o,
    output logic              clk_run_o,
    output logic [1:0]        burst_mode_o
);

    localparam int AP_BIT  = 10;
    localparam int OTF_BIT = 12;

    logic             accept;
    logic             run;
    logic [STB_W-1:0] kind;
    logic             bl8_now;
    logic             mrs_load;

    logic [STB_W-1:0]  stb_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] row_q;
    logic [COL_W-1:0]  col_q;
    logic              ap_q;
    logic              bl8_q;
    logic [1:0]        mri_q;
    logic [ADDR_W-1:0] mro_q;

    cke_fsm u_cke (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .cke_i    (cke_i),
        .accept_o (accept),
        .run_o    (run)
    );

    cmd_classify u_cls (
        .cs_n_i     (cs_n_i),
        .ras_n_i    (ras_n_i),
        .cas_n_i    (cas_n_i),
        .we_n_i     (we_n_i),
        .all_bank_i (addr_i[AP_BIT]),
        .kind_o     (kind)
    );

    assign mrs_load = accept && kind[S_MRS];

    burst_ctl u_burst (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .load_i    (mrs_load),
        .mr_idx_i  (ba_i[1:0]),
        .op_i      (addr_i[1:0]),
        .otf_sel_i (addr_i[OTF_BIT]),
        .mode_o    (burst_mode_o),
        .bl8_o     (bl8_now)
    );

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            stb_q  <= '0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            ap_q   <= 1'b0;
            bl8_q  <= 1'b0;
            mri_q  <= '0;
            mro_q  <= '0;
        end else begin
            stb_q <= accept ? kind : '0;
            if (accept) begin
                if (kind[S_ACT]) begin
                    bank_q <= ba_i;
                    row_q  <= addr_i;
                end
                if (kind[S_RD] || kind[S_WR]) begin
                    bank_q <= ba_i;
                    col_q  <= addr_i[COL_W-1:0];
                    ap_q   <= addr_i[AP_BIT];
                    bl8_q  <= bl8_now;
                end
                if (kind[S_PRE]) begin
                    bank_q <= ba_i;
                end
                if (kind[S_MRS]) begin
                    mri_q <= ba_i[1:0];
                    mro_q <= addr_i;
                end
            end
        end
    end

    assign cmd_stb_o  = stb_q;
    assign bank_o     = bank_q;
    assign row_o      = row_q;
    assign col_o      = col_q;
    assign auto_pre_o = ap_q;
    assign burst8_o   = bl8_q;
    assign mr_idx_o   = mri_q;
    assign mr_op_o    = mro_q;
    assign clk_run_o  = run;

    // R1: never more than one command strobe
    p_stb_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0(cmd_stb_o));

    // R9: clock enable sampled low gives no strobe and holds the bank
    p_cke_low_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !cke_i |=> (cmd_stb_o == '0) && $stable(bank_o));

    // R2: deselect while running gives only the NOP strobe
    p_deselect_nop_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cke_i && clk_run_o && cs_n_i) |=> (cmd_stb_o == 8'h80));

    // R4: the precharge flavour follows address bit 10 at the sampling edge
    p_prea_a10_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cmd_stb_o[S_PREA] |-> $past(addr_i[AP_BIT]));
    p_pre_a10_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cmd_stb_o[S_PRE] |-> !$past(addr_i[AP_BIT]));

    // R8: fixed chop-4 mode never reports length-8 on an access
    p_fix4_chop_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ((cmd_stb_o[S_RD] || cmd_stb_o[S_WR]) && (burst_mode_o == 2'b10)) |-> !burst8_o);

endmodule

// File: tb/ddr_cmd_decode_test.sv
module ddr_cmd_decode_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [2:0]  ba;
    logic [15:0] addr;
    logic [7:0]  stb;
    logic [2:0]  bank;
    logic [15:0] row;
    logic [9:0]  col;
    logic        ap, bl8;
    logic [1:0]  mri;
    logic [15:0] mro;
    logic        run;
    logic [1:0]  bmode;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic        m_run;
    logic [1:0]  m_mode;
    logic [7:0]  e_stb;
    logic [2:0]  e_bank;
    logic [15:0] e_row, e_mro;
    logic [9:0]  e_col;
    logic        e_ap, e_bl8;
    logic [1:0]  e_mri;

    always #4 clk = ~clk;

    ddr_cmd_decode uut (
        .clk_i(clk), .rst_n_i(rst_n), .cke_i(cke), .cs_n_i(cs_n),
        .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr),
        .cmd_stb_o(stb), .bank_o(bank), .row_o(row), .col_o(col),
        .auto_pre_o(ap), .burst8_o(bl8), .mr_idx_o(mri), .mr_op_o(mro),
        .clk_run_o(run), .burst_mode_o(bmode)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] want_stb(input logic c, input logic r,
                                            input logic k, input logic w, input logic a10);
        logic [2:0] code;
        code = {r, k, w};
        if (c) return 8'h80;
        case (code)
            3'b011: return 8'h01;
            3'b101: return 8'h02;
            3'b100: return 8'h04;
            3'b010: return a10 ? 8'h10 : 8'h08;
            3'b001: return 8'h20;
            3'b000: return 8'h40;
            3'b111: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_run = 1'b0; m_mode = 2'b00; e_stb = '0; e_bank = '0; e_row = '0;
        e_col = '0; e_ap = 1'b0; e_bl8 = 1'b0; e_mri = '0; e_mro = '0;
    endtask

    task automatic check_all(input string tag);
        chk((tag == "") ? "R3" : tag, "strobe", 32'(stb), 32'(e_stb));
        chk((tag == "") ? "R6" : tag, "bank", 32'(bank), 32'(e_bank));
        chk((tag == "") ? "R6" : tag, "row", 32'(row), 32'(e_row));
        chk((tag == "") ? "R5" : tag, "col", 32'(col), 32'(e_col));
        chk((tag == "") ? "R5" : tag, "auto_pre", 32'(ap), 32'(e_ap));
        chk((tag == "") ? "R8" : tag, "burst8", 32'(bl8), 32'(e_bl8));
        chk((tag == "") ? "R7" : tag, "mr_idx", 32'(mri), 32'(e_mri));
        chk((tag == "") ? "R7" : tag, "mr_op", 32'(mro), 32'(e_mro));
        chk((tag == "") ? "R7" : tag, "burst_mode", 32'(bmode), 32'(m_mode));
        chk((tag == "") ? "R9" : tag, "clk_run", 32'(run), 32'(m_run));
    endtask

    task automatic step(input logic k_e, input logic c, input logic r, input logic k,
                        input logic w, input logic [2:0] b, input logic [15:0] a);
        logic  acc;
        string tag;
        cke = k_e; cs_n = c; ras_n = r; cas_n = k; we_n = w; ba = b; addr = a;
        @(negedge clk);
        acc   = k_e && m_run;
        m_run = k_e;
        e_stb = acc ? want_stb(c, r, k, w, a[10]) : 8'h00;
        tag   = "";
        if (!acc) tag = "R9";
        else if (c) tag = "R2";
        else if (e_stb[3] || e_stb[4]) tag = "R4";
        if (e_stb[0]) begin e_bank = b; e_row = a; end
        if (e_stb[1] || e_stb[2]) begin
            e_bank = b; e_col = a[9:0]; e_ap = a[10];
            e_bl8 = (m_mode == 2'b10) ? 1'b0 : ((m_mode == 2'b01) ? a[12] : 1'b1);
        end
        if (e_stb[3]) e_bank = b;
        if (e_stb[6]) begin
            e_mri = b[1:0]; e_mro = a;
            if (b[1:0] == 2'b00) m_mode = a[1:0];
            else tag = "R11";
        end
        check_all(tag);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cke = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1;
        we_n = 1'b1; ba = '0; addr = '0;
        model_reset();
        @(negedge clk); @(negedge clk);
        check_all("R10");
        rst_n = 1'b1;

        // R9: first high clock-enable edge only wakes the decoder
        step(1, 0, 1, 0, 1, 3'd5, 16'h0123);
        step(1, 1, 1, 1, 1, 3'd0, 16'h0000);

        // R3 R4 R5 R6 R8 R2: full control sweep under each burst mode
        for (int md = 0; md < 4; md++) begin
            step(1, 0, 0, 0, 0, 3'd0, 16'(md) | 16'hA400);
            for (int k = 0; k < 64; k++) begin
                logic [15:0] a;
                logic [2:0]  b;
                a = 16'(k * 16'h0b3d + md * 16'h1111);
                a[10] = k[4];
                a[12] = k[5];
                b = {k[4], 2'(1 + (k % 3))};
                step(1, k[3], k[2], k[1], k[0], b, a);
            end
        end

        // R11: load to index 2 leaves the burst mode alone
        step(1, 0, 0, 0, 0, 3'd0, 16'h0001);
        step(1, 0, 0, 0, 0, 3'd2, 16'h0002);
        step(1, 0, 1, 0, 1, 3'd3, 16'h1155);

        // R9: clock enable low, commands and fields frozen
        step(0, 0, 1, 0, 1, 3'd6, 16'h0777);
        step(0, 0, 0, 1, 1, 3'd1, 16'hFFFF);
        step(0, 0, 0, 0, 0, 3'd0, 16'h0002);
        step(1, 0, 1, 0, 0, 3'd7, 16'h1234);
        step(1, 0, 1, 0, 0, 3'd7, 16'h1234);

        // R10: asynchronous reset between edges
        step(1, 0, 0, 0, 0, 3'd0, 16'h0002);
        #2 rst_n = 1'b0;
        #1 model_reset();
        check_all("R10");
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 1, 1, 1, 1, 3'd0, 16'h0000);
        step(1, 0, 1, 0, 1, 3'd4, 16'h0321);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule